// File: doc/BRIEF.md
# Memory-Mapped Event Timer with One Comparator

This block is a free-running event timer that software reaches through a plain 32-bit register port with a byte address. A main counter advances by one on every clock while the run bit of the global control register is set. One comparator channel watches the counter. When the count equals the comparator value, an event fires. The event is reported on one interrupt output, either as a held level that software clears or as a single-cycle pulse.

The channel works in one-shot or periodic mode. In periodic mode the comparator moves forward by a stored period after each match. A self-clearing value-set control decides whether a comparator write loads both the comparator and the period, or only the period. A read-only capability word reports the counter tick period in femtoseconds, so software can work out the count rate. The register read path is combinational: `rd_data` follows `addr` in the same cycle. Writes take effect at the clock edge on which `wr_en` is high.

Top module: `evtmr_top`

## Requirements
- R1: After reset, the global control reads 0, the main counter reads 0, interrupt status reads 0, channel config reads 0, the comparator reads 0xFFFFFFFF and `irq` is low.
- R2: Address 0x04 reads the parameter `PERIOD_FS` (default 10000000). Writes to 0x04 do not change it.
- R3: While global control bit 0 (run) is 1, the counter at 0xF0 increases by one per clock. While run is 0 it holds its value. A write to 0xF0 loads the counter and takes priority over counting.
- R4: Global control (0x10) stores bit 1 (routing flag) and bit 0 (run). All its other bits read 0.
- R5: An event occurs in a cycle where run is 1 and the counter equals the comparator. The compare is exact on 32 bits, so a comparator value behind the counter matches only after the counter wraps through zero. In level mode, status bit 0 at 0x20 reads 1 from the clock edge that ends the match cycle.
- R6: In level mode (channel config bit 1 = 1), `irq` equals status AND interrupt enable (channel config bit 2). Writing 1 to bit 0 of 0x20 clears the status, and `irq` falls with it.
- R7: In edge mode (bit 1 = 0), each event drives `irq` high for exactly one cycle, one edge after the match cycle. Status stays 0, and writes to 0x20 have no effect.
- R8: With interrupt enable at 0, `irq` stays low, while level-mode status still records the event.
- R9: In periodic mode (bit 3 = 1) with value-set (bit 6) at 1, a write to 0x108 loads both the comparator and the period. Bit 6 then reads 0.
- R10: In periodic mode each event advances the comparator by the period. In one-shot mode an event leaves the comparator unchanged.
- R11: In periodic mode with value-set at 0, a write to 0x108 changes only the period, and the comparator read back is unchanged. In one-shot mode a write to 0x108 loads the comparator.
- R12: Channel config (0x100) stores bits 1, 2, 3, 6, 8, 14 and the 5-bit route field at bits 13:9. A write of all ones reads back 0x00007F4E. Bits 8 and 14 have no effect on behaviour.
- R13: Addresses outside the six mapped registers read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | ADDR_W | Byte address of the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | Timer interrupt, level or pulse |

## Verification
Most faults in this block change when the interrupt happens rather than whether it happens. A counter that skips, fails to hold, or compares with the wrong width moves the `irq` edge by one or more cycles, or removes it altogether. The bench therefore checks the exact cycle of each edge, one clock after the match cycle, and also checks the cycle just before it. Faults in the periodic reload and value-set logic do not show until the following event. To catch them, the comparator is read back right after each match and after each comparator write. A broken status clear or a broken edge/level selection shows at once on `irq` and at address 0x20.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;

   localparam int unsigned REG_W = 32;

   // byte addresses of the mapped registers
   localparam logic [15:0] ADR_CAPS  = 16'h0004;
   localparam logic [15:0] ADR_GCTL  = 16'h0010;
   localparam logic [15:0] ADR_STAT  = 16'h0020;
   localparam logic [15:0] ADR_COUNT = 16'h00F0;
   localparam logic [15:0] ADR_CHCFG = 16'h0100;
   localparam logic [15:0] ADR_CHCMP = 16'h0108;

   // global control bit positions
   localparam int unsigned GB_RUN   = 0;
   localparam int unsigned GB_ROUTE = 1;

   // channel config bit positions
   localparam int unsigned CB_LEVEL  = 1;
   localparam int unsigned CB_IEN    = 2;
   localparam int unsigned CB_PER    = 3;
   localparam int unsigned CB_VSET   = 6;
   localparam int unsigned CB_W32    = 8;
   localparam int unsigned CB_RT_LO  = 9;
   localparam int unsigned CB_RT_W   = 5;
   localparam int unsigned CB_BUSMSG = 14;

   typedef struct packed {
      logic               bus_msg;
      logic [CB_RT_W-1:0] route;
      logic               force32;
      logic               val_set;
      logic               periodic;
      logic               irq_en;
      logic               level;
   } chan_cfg_t;

endpackage

// File: rtl/evtmr_counter.sv
module evtmr_counter #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] count
);

   generate
      if (W < 8) begin : g_bad_w
         $error("evtmr_counter: W too small");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      count <= '0;
      else if (load)   count <= load_val;
      else if (run)    count <= count + 1'b1;
   end

   // R3: counter holds while stopped
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load) |=> (count == $past(count)));

   // R3: counter steps by one while running
   a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load) |=> (count == $past(count) + 1'b1));

   // R3: load takes priority
   a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (count == $past(load_val)));

endmodule

// File: rtl/evtmr_channel.sv
module evtmr_channel
   import evtmr_pkg::*;
#(
   parameter int unsigned W            = 32,
   parameter logic [W-1:0] CMP_RESET   = '1,
   parameter bit          HAS_PERIODIC = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic [W-1:0] count,
   input  logic [W-1:0] wdata,
   input  logic         cfg_we,
   input  logic         cmp_we,
   input  logic         stat_w1c,
   output logic [W-1:0] cfg_rd,
   output logic [W-1:0] cmp_q,
   output logic         stat_q,
   output logic         irq
);

   generate
      if (W != REG_W) begin : g_bad_w
         $error("evtmr_channel: W must equal REG_W");
      end
   endgenerate

   chan_cfg_t    cfg_q;
   logic [W-1:0] period_q;
   logic         match;
   logic         pulse_q;
   logic         per_wr;

   // periodic bit is only writable when the variant supports it
   generate
      if (HAS_PERIODIC) begin : g_per
         assign per_wr = wdata[CB_PER];
      end else begin : g_noper
         assign per_wr = 1'b0;
      end
   endgenerate

   assign match = run && (count == cmp_q);

   // configuration register
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (cfg_we) begin
         cfg_q.level    <= wdata[CB_LEVEL];
         cfg_q.irq_en   <= wdata[CB_IEN];
         cfg_q.periodic <= per_wr;
         cfg_q.val_set  <= wdata[CB_VSET];
         cfg_q.force32  <= wdata[CB_W32];
         cfg_q.route    <= wdata[CB_RT_LO +: CB_RT_W];
         cfg_q.bus_msg  <= wdata[CB_BUSMSG];
      end else if (cmp_we && cfg_q.periodic && cfg_q.val_set) begin
         cfg_q.val_set  <= 1'b0;
      end
   end

   // comparator and period
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_q    <= CMP_RESET;
         period_q <= '0;
      end else if (cmp_we) begin
         if (cfg_q.periodic) begin
            period_q <= wdata;
            if (cfg_q.val_set) cmp_q <= wdata;
         end else begin
            cmp_q <= wdata;
         end
      end else if (match && cfg_q.periodic) begin
         cmp_q <= cmp_q + period_q;
      end
   end

   // status (level mode only) and edge pulse
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q  <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         if (match && cfg_q.level)          stat_q <= 1'b1;
         else if (stat_w1c && cfg_q.level)  stat_q <= 1'b0;
         pulse_q <= match && !cfg_q.level && cfg_q.irq_en;
      end
   end

   assign irq = cfg_q.level ? (stat_q && cfg_q.irq_en) : pulse_q;

   always_comb begin
      cfg_rd                          = '0;
      cfg_rd[CB_LEVEL]                = cfg_q.level;
      cfg_rd[CB_IEN]                  = cfg_q.irq_en;
      cfg_rd[CB_PER]                  = cfg_q.periodic;
      cfg_rd[CB_VSET]                 = cfg_q.val_set;
      cfg_rd[CB_W32]                  = cfg_q.force32;
      cfg_rd[CB_RT_LO +: CB_RT_W]     = cfg_q.route;
      cfg_rd[CB_BUSMSG]               = cfg_q.bus_msg;
   end

   // R5: status only rises after a level-mode match
   a_r5_stat_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q) |-> $past(match && cfg_q.level));

   // R6: level-mode clear without a competing match drops status
   a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_w1c && cfg_q.level && !match && !cfg_we) |=> !stat_q);

   // R9: value-set drops after the comparator write in periodic mode
   a_r9_vset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_we && cfg_q.periodic && !cfg_we) |=> !cfg_q.val_set);

   // R10: periodic match advances by the period
   a_r10_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (match && cfg_q.periodic && !cmp_we) |=> (cmp_q == $past(cmp_q) + $past(period_q)));

   // R7: edge pulse only follows a match
   a_r7_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_q) |-> $past(match));

endmodule

// File: rtl/evtmr_top.sv
module evtmr_top
   import evtmr_pkg::*;
#(
   parameter int unsigned ADDR_W       = 12,
   parameter logic [31:0] PERIOD_FS    = 32'd10_000_000,
   parameter logic [31:0] CMP_RESET    = 32'hFFFF_FFFF,
   parameter bit          HAS_PERIODIC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wr_data,
   output logic [31:0]       rd_data,
   output logic              irq
);

   localparam int unsigned AX_W = 16;

   generate
      if (ADDR_W < 9 || ADDR_W > AX_W) begin : g_bad_addr
         $error("evtmr_top: ADDR_W must lie in 9..16");
      end
      if (PERIOD_FS == 32'd0) begin : g_bad_period
         $error("evtmr_top: PERIOD_FS must be nonzero");
      end
   endgenerate

   logic [AX_W-1:0]  addr_x;
   logic             run_q;
   logic             route_q;
   logic [REG_W-1:0] count;
   logic [REG_W-1:0] cfg_rd;
   logic [REG_W-1:0] cmp_q;
   logic             stat_q;
   logic             we_count, we_cfg, we_cmp, we_gctl, w1c_stat;

   assign addr_x   = AX_W'(addr);
   assign we_gctl  = wr_en && (addr_x == ADR_GCTL);
   assign we_count = wr_en && (addr_x == ADR_COUNT);
   assign we_cfg   = wr_en && (addr_x == ADR_CHCFG);
   assign we_cmp   = wr_en && (addr_x == ADR_CHCMP);
   assign w1c_stat = wr_en && (addr_x == ADR_STAT) && wr_data[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         route_q <= 1'b0;
      end else if (we_gctl) begin
         run_q   <= wr_data[GB_RUN];
         route_q <= wr_data[GB_ROUTE];
      end
   end

   evtmr_counter #(.W(REG_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_q),
      .load     (we_count),
      .load_val (wr_data),
      .count    (count)
   );

   evtmr_channel #(
      .W            (REG_W),
      .CMP_RESET    (CMP_RESET),
      .HAS_PERIODIC (HAS_PERIODIC)
   ) u_chan0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_q),
      .count    (count),
      .wdata    (wr_data),
      .cfg_we   (we_cfg),
      .cmp_we   (we_cmp),
      .stat_w1c (w1c_stat),
      .cfg_rd   (cfg_rd),
      .cmp_q    (cmp_q),
      .stat_q   (stat_q),
      .irq      (irq)
   );

   always_comb begin
      rd_data = '0;
      case (addr_x)
         ADR_CAPS:  rd_data = PERIOD_FS;
         ADR_GCTL:  begin
            rd_data[GB_RUN]   = run_q;
            rd_data[GB_ROUTE] = route_q;
         end
         ADR_STAT:  rd_data[0] = stat_q;
         ADR_COUNT: rd_data = count;
         ADR_CHCFG: rd_data = cfg_rd;
         ADR_CHCMP: rd_data = cmp_q;
         default:   rd_data = '0;
      endcase
   end

   // R4: global control keeps its stored value without a write
   a_r4_gctl_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !we_gctl |=> ($stable(run_q) && $stable(route_q)));

   // R8: with interrupt enable off for two cycles the output stays low
   a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_rd[CB_IEN] && !$past(cfg_rd[CB_IEN])) |-> !irq);

endmodule

// File: tb/evtmr_top_tb.sv
module evtmr_top_tb;

   localparam int unsigned AW = 12;
   localparam logic [31:0] PFS = 32'd10_000_000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0]   wr_data = '0;
   logic [31:0]   rd_data;
   logic          irq;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   evtmr_top #(.ADDR_W(AW), .PERIOD_FS(PFS)) u_dut (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .addr (addr),
      .wr_data (wr_data), .rd_data (rd_data), .irq (irq)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      addr = AW'(a); wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [31:0] d);
      addr = AW'(a);
      #1 d = rd_data;
   endtask

   task automatic rd_check(input string tag, input logic [15:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      check(tag, v, exp);
   endtask

   task automatic t_reset();
      rd_check("R1 gctl", 16'h010, 32'h0);
      rd_check("R1 count", 16'h0F0, 32'h0);
      rd_check("R1 status", 16'h020, 32'h0);
      rd_check("R1 chcfg", 16'h100, 32'h0);
      rd_check("R1 cmp", 16'h108, 32'hFFFF_FFFF);
      check("R1 irq", {31'd0, irq}, 32'h0);
   endtask

   task automatic t_regs();
      rd_check("R2 caps", 16'h004, PFS);
      wr(16'h004, 32'h0);
      rd_check("R2 caps after write", 16'h004, PFS);
      wr(16'h010, 32'hFFFF_FFFE);
      rd_check("R4 gctl stored", 16'h010, 32'h2);
      wr(16'h010, 32'h0);
      wr(16'h100, 32'hFFFF_FFFF);
      rd_check("R12 chcfg all ones", 16'h100, 32'h0000_7F4E);
      wr(16'h100, 32'h0);
      rd_check("R12 chcfg cleared", 16'h100, 32'h0);
      rd_check("R13 unmapped 0x000", 16'h000, 32'h0);
      wr(16'h200, 32'hDEAD_BEEF);
      rd_check("R13 unmapped 0x200", 16'h200, 32'h0);
   endtask

   task automatic t_count();
      wr(16'h0F0, 32'd1000);
      step(3);
      rd_check("R3 hold while stopped", 16'h0F0, 32'd1000);
      wr(16'h010, 32'h1);
      rd_check("R3 no step at enable edge", 16'h0F0, 32'd1000);
      step(4);
      rd_check("R3 counts by one", 16'h0F0, 32'd1004);
      wr(16'h010, 32'h0);
      rd_check("R3 last step", 16'h0F0, 32'd1005);
      step(2);
      rd_check("R3 hold after stop", 16'h0F0, 32'd1005);
   endtask

   // arm: stop, load counter and comparator, start; returns at k=0
   task automatic arm(input logic [31:0] cfg, input logic [31:0] c, input logic [31:0] cmp);
      wr(16'h010, 32'h0);
      wr(16'h100, cfg);
      wr(16'h0F0, c);
      wr(16'h108, cmp);
      wr(16'h010, 32'h1);
   endtask

   task automatic t_level();
      arm(32'h6, 32'd100, 32'd105);
      step(5);
      check("R5 irq low before match", {31'd0, irq}, 32'h0);
      step(1);
      check("R6 irq level high", {31'd0, irq}, 32'h1);
      rd_check("R5 status set", 16'h020, 32'h1);
      step(2);
      check("R6 irq held", {31'd0, irq}, 32'h1);
      wr(16'h020, 32'h1);
      rd_check("R6 status cleared", 16'h020, 32'h0);
      check("R6 irq cleared", {31'd0, irq}, 32'h0);
      rd_check("R10 one-shot cmp kept", 16'h108, 32'd105);
   endtask

   task automatic t_masked();
      arm(32'h2, 32'd100, 32'd103);
      step(4);
      rd_check("R8 status recorded", 16'h020, 32'h1);
      check("R8 irq masked", {31'd0, irq}, 32'h0);
      wr(16'h020, 32'h1);
   endtask

   task automatic t_edge();
      arm(32'h4, 32'd200, 32'd202);
      step(2);
      check("R7 low before pulse", {31'd0, irq}, 32'h0);
      step(1);
      check("R7 pulse high", {31'd0, irq}, 32'h1);
      rd_check("R7 status stays 0", 16'h020, 32'h0);
      step(1);
      check("R7 pulse one cycle", {31'd0, irq}, 32'h0);
      wr(16'h020, 32'h1);
      rd_check("R7 status write ignored", 16'h020, 32'h0);
   endtask

   task automatic t_wrap();
      arm(32'h6, 32'hFFFF_FFFE, 32'd1);
      step(3);
      check("R5 no fire before wrap", {31'd0, irq}, 32'h0);
      step(1);
      check("R5 fire after wrap", {31'd0, irq}, 32'h1);
      wr(16'h020, 32'h1);
   endtask

   task automatic t_periodic();
      arm(32'h4E, 32'd0, 32'd10);
      rd_check("R9 value-set self clears", 16'h100, 32'h0000_000E);
      rd_check("R9 cmp loaded", 16'h108, 32'd10);
      step(10);
      check("R10 low before first", {31'd0, irq}, 32'h0);
      step(1);
      check("R10 first event", {31'd0, irq}, 32'h1);
      rd_check("R10 cmp advanced", 16'h108, 32'd20);
      wr(16'h020, 32'h1);
      step(8);
      check("R10 low before second", {31'd0, irq}, 32'h0);
      step(1);
      check("R10 second event", {31'd0, irq}, 32'h1);
      rd_check("R10 cmp advanced again", 16'h108, 32'd30);
      wr(16'h010, 32'h0);
      wr(16'h020, 32'h1);
      wr(16'h108, 32'd500);
      rd_check("R11 cmp kept without value-set", 16'h108, 32'd30);
      wr(16'h0F0, 32'd28);
      wr(16'h010, 32'h1);
      step(3);
      check("R11 event with new period", {31'd0, irq}, 32'h1);
      rd_check("R11 new period applied", 16'h108, 32'd530);
      wr(16'h010, 32'h0);
      wr(16'h020, 32'h1);
      wr(16'h100, 32'h6);
      wr(16'h108, 32'd77);
      rd_check("R11 one-shot write loads cmp", 16'h108, 32'd77);
   endtask

   initial begin
      #(20 * 100_000);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      step(4);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_regs();
      t_count();
      t_level();
      t_masked();
      t_edge();
      t_wrap();
      t_periodic();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule